// File: doc/BRIEF.md
# I2C Master Clock Rate Generator

This block times the serial clock line of an I2C bus master. A 9-bit reload value sets how long each low half and each high half of the clock lasts. A down-counter is loaded with this value at the start of each half. It decrements on a pacing strobe, stops at zero and waits there until the next load. When the low half runs out, the block lets go of the line. The high half is not timed until the synchronized line actually reads high. A slave that holds the clock low therefore stretches the period, and the master stays in step with it.

The line is open-drain, so the block only ever asks for it to be pulled low. A byte-level controller enables the block and gets a one-cycle strobe at each half boundary. A reload value of zero is refused and flagged. A reload value for a target rate is roughly the decrement rate divided by twice the bus rate, minus one. The exact reload value and its rate error follow from the phase lengths given below.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, `sclDriveLow`, `phaseTick` and `reloadInvalid` are all 0.
- R2: Each low half keeps `sclDriveLow` at 1 for exactly CLKS_PER_DEC*reload+1 clock cycles. This holds for the first low half after enable rises and for every later one. The reload value is taken at the start of each half.
- R3: With the line free, each high half keeps `sclDriveLow` at 0 for exactly CLKS_PER_DEC*reload+SYNC_STAGES+2 cycles. The extra cycles are the synchronizer stages plus one cycle to detect the line and one cycle to expire.
- R4: Each extra cycle that a slave holds the line low after release lengthens the released interval by exactly one cycle.
- R5: While the line stays low after release, the counter holds and the block never pulls the line low and gives no strobe, however long the wait.
- R6: `phaseTick` is a one-cycle pulse in the first cycle of each released interval and in the first cycle of each low half after a high half. That makes two per period. The low half that starts from idle gets no pulse.
- R7: With enable at 1 and reload equal to 0, `reloadInvalid` is 1 from the next cycle on and `sclDriveLow` stays 0.
- R8: One cycle after enable is sampled 0, `sclDriveLow` is 0. A later rise of enable starts a full low half again, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; a rise starts a low half |
| reloadVal | input | RELOAD_W | Half-period reload value; 0 is invalid |
| sclIn | input | 1 | Raw sampled level of the clock line |
| sclDriveLow | output | 1 | 1 = pull the line low, 0 = release it |
| phaseTick | output | 1 | One-cycle strobe at each half boundary |
| reloadInvalid | output | 1 | Enable is set while the reload value is 0 |

## Verification
All three outputs are registered. Each takes effect on the edge after the state change that causes it. The bench drives every input at the falling edge and samples at the falling edge. It measures each half as a run of consecutive samples, so every phase length is counted to the cycle. A behavioural slave closes the loop on the line and can hold it low for a chosen number of cycles. From this, the bench predicts the released length as CLKS_PER_DEC*reload+SYNC_STAGES+2 plus the hold. Disable and zero-reload responses are due one cycle after the input is sampled, and they are read at the next falling edge.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_LOW       = 2'd1,
    PH_WAIT_HIGH = 2'd2,
    PH_HIGH      = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic clear;
  } dpCtrl_t;

endpackage

// File: rtl/scl_gen_datapath.sv
module scl_gen_datapath
  import scl_gen_pkg::*;
#(
  parameter int RELOAD_W     = 9,
  parameter int CLKS_PER_DEC = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctrl,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                sclIn,
  output logic                countZero,
  output logic                sclHigh
);

  // line synchronizer
  logic [SYNC_STAGES-1:0] syncChain;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= sclIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], sclIn};
      end
    end
  endgenerate
  assign sclHigh = syncChain[SYNC_STAGES-1];

  // decrement pacing strobe, restarted on every load
  logic decEn;
  generate
    if (CLKS_PER_DEC <= 1) begin : g_pace_every
      assign decEn = 1'b1;
    end else begin : g_pace_div
      localparam int PACE_W = $clog2(CLKS_PER_DEC);
      localparam logic [PACE_W-1:0] PACE_LAST = PACE_W'(CLKS_PER_DEC - 1);
      logic [PACE_W-1:0] paceCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                       paceCnt <= '0;
        else if (ctrl.load || ctrl.clear) paceCnt <= '0;
        else if (paceCnt == PACE_LAST)   paceCnt <= '0;
        else                             paceCnt <= paceCnt + 1'b1;
      end
      assign decEn = (paceCnt == PACE_LAST);
    end
  endgenerate

  // saturating down-counter
  logic [RELOAD_W-1:0] halfCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         halfCnt <= '0;
    else if (ctrl.clear)               halfCnt <= '0;
    else if (ctrl.load)                halfCnt <= reloadVal;
    else if (decEn && halfCnt != '0)   halfCnt <= halfCnt - 1'b1;
  end
  assign countZero = (halfCnt == '0);

endmodule

// File: rtl/scl_gen_ctrl.sv
module scl_gen_ctrl
  import scl_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    reloadZero,
  input  logic    countZero,
  input  logic    sclHigh,
  output dpCtrl_t ctrl,
  output logic    sclDriveLow,
  output logic    phaseTick,
  output logic    reloadInvalid
);

  phase_e phase, phaseNext;
  logic   boundary;

  always_comb begin
    phaseNext  = phase;
    ctrl.load  = 1'b0;
    ctrl.clear = 1'b0;
    boundary   = 1'b0;
    if (!enable || reloadZero) begin
      phaseNext  = PH_IDLE;
      ctrl.clear = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseNext = PH_LOW;
          ctrl.load = 1'b1;
        end
        PH_LOW: begin
          if (countZero) begin
            phaseNext = PH_WAIT_HIGH;
            boundary  = 1'b1;
          end
        end
        PH_WAIT_HIGH: begin
          if (sclHigh) begin
            phaseNext = PH_HIGH;
            ctrl.load = 1'b1;
          end
        end
        PH_HIGH: begin
          if (countZero) begin
            phaseNext = PH_LOW;
            ctrl.load = 1'b1;
            boundary  = 1'b1;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase         <= PH_IDLE;
      sclDriveLow   <= 1'b0;
      phaseTick     <= 1'b0;
      reloadInvalid <= 1'b0;
    end else begin
      phase         <= phaseNext;
      sclDriveLow   <= (phaseNext == PH_LOW);
      phaseTick     <= boundary;
      reloadInvalid <= enable && reloadZero;
    end
  end

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_gen_pkg::*;
#(
  parameter int RELOAD_W     = 9,
  parameter int CLKS_PER_DEC = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                sclIn,
  output logic                sclDriveLow,
  output logic                phaseTick,
  output logic                reloadInvalid
);

  dpCtrl_t dpCtrl;
  logic    countZero;
  logic    sclHigh;
  logic    reloadZero;

  assign reloadZero = (reloadVal == '0);

  scl_gen_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .reloadZero    (reloadZero),
    .countZero     (countZero),
    .sclHigh       (sclHigh),
    .ctrl          (dpCtrl),
    .sclDriveLow   (sclDriveLow),
    .phaseTick     (phaseTick),
    .reloadInvalid (reloadInvalid)
  );

  scl_gen_datapath #(
    .RELOAD_W     (RELOAD_W),
    .CLKS_PER_DEC (CLKS_PER_DEC),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (dpCtrl),
    .reloadVal (reloadVal),
    .sclIn     (sclIn),
    .countZero (countZero),
    .sclHigh   (sclHigh)
  );

endmodule

// File: rtl/scl_gen_checker.sv
module scl_gen_checker #(
  parameter int RELOAD_W = 9
) (
  input logic                clk,
  input logic                rstN,
  input logic                enable,
  input logic [RELOAD_W-1:0] reloadVal,
  input logic                sclDriveLow,
  input logic                phaseTick,
  input logic                reloadInvalid
);

  // R8: disable releases the line on the next cycle
  p_release_on_disable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sclDriveLow);

  // R7: zero reload is flagged and never drives the line
  p_zero_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && reloadVal == '0) |=> (reloadInvalid && !sclDriveLow));

  // R6: a strobe only accompanies a change of the drive
  p_tick_on_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    phaseTick |-> (sclDriveLow != $past(sclDriveLow)));

  // R6: strobe lasts one cycle
  p_tick_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    phaseTick |=> !phaseTick);

  // R2: the line is never pulled low for a single cycle only
  p_low_min_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclDriveLow) && enable && reloadVal != '0) |=> sclDriveLow);

endmodule

bind scl_rate_gen scl_gen_checker #(.RELOAD_W(RELOAD_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .enable        (enable),
  .reloadVal     (reloadVal),
  .sclDriveLow   (sclDriveLow),
  .phaseTick     (phaseTick),
  .reloadInvalid (reloadInvalid)
);

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;

  localparam int RELOAD_W = 9;
  localparam int DIV      = 2;
  localparam int SYNC     = 2;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                enable = 1'b0;
  logic [RELOAD_W-1:0] reloadVal = '0;
  logic                sclIn;
  logic                sclDriveLow;
  logic                phaseTick;
  logic                reloadInvalid;

  int checks = 0;
  int fails  = 0;
  int stretch = 0;
  int holdCnt = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // behavioural slave: holds the line low stretch cycles past release
  always @(negedge clk) begin
    if (!rstN)            holdCnt = 0;
    else if (sclDriveLow) holdCnt = stretch + 1;
    else if (holdCnt > 0) holdCnt = holdCnt - 1;
  end
  assign sclIn = !(sclDriveLow || (holdCnt != 0));

  scl_rate_gen #(.RELOAD_W(RELOAD_W), .CLKS_PER_DEC(DIV), .SYNC_STAGES(SYNC)) i_scl_rate_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .reloadVal(reloadVal), .sclIn(sclIn),
    .sclDriveLow(sclDriveLow), .phaseTick(phaseTick), .reloadInvalid(reloadInvalid)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // counts consecutive negedge samples with drive == level
  task automatic run_len(input logic level, output int len, output int ticks, output int firstTick);
    len = 0; ticks = 0; firstTick = phaseTick;
    while (sclDriveLow == level) begin
      len++;
      if (phaseTick) ticks++;
      @(negedge clk);
    end
  endtask

  task automatic period(input int r, input int s);
    int lenA, tkA, ftA, lenB, tkB, ftB, lenC, tkC, ftC;
    reloadVal = RELOAD_W'(r);
    stretch = s;
    enable = 1'b1;
    @(negedge clk);
    run_len(1'b1, lenA, tkA, ftA);
    run_len(1'b0, lenB, tkB, ftB);
    run_len(1'b1, lenC, tkC, ftC);
    check(lenA == DIV*r+1, "R2 first low", lenA, DIV*r+1);
    check(lenC == DIV*r+1, "R2 later low", lenC, DIV*r+1);
    if (s == 0) check(lenB == DIV*r+SYNC+2, "R3 high", lenB, DIV*r+SYNC+2);
    else        check(lenB == DIV*r+SYNC+2+s, "R4 stretched high", lenB, DIV*r+SYNC+2+s);
    check(tkA == 0, "R6 no tick from idle", tkA, 0);
    check(tkB == 1 && ftB == 1, "R6 release tick", tkB*10+ftB, 11);
    check(tkC == 1 && ftC == 1, "R6 low tick", tkC*10+ftC, 11);
    enable = 1'b0;
    stretch = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        check(1'b0, "watchdog", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sclDriveLow == 1'b0, "R1 drive", int'(sclDriveLow), 0);
    check(phaseTick == 1'b0, "R1 tick", int'(phaseTick), 0);
    check(reloadInvalid == 1'b0, "R1 invalid", int'(reloadInvalid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R6 sweep of small reload values and the largest one
    for (int r = 1; r <= 24; r++) period(r, 0);
    period(511, 0);

    // R4 stretching
    for (int s = 1; s <= 8; s++) period(3, s);

    // R5 long hold: counter waits at zero with the line low
    reloadVal = 9'd2; stretch = 3000; enable = 1'b1;
    @(negedge clk);
    while (sclDriveLow) @(negedge clk);
    seen = 0;
    for (int i = 0; i < 2900; i++) begin
      @(negedge clk);
      if (sclDriveLow || phaseTick) seen++;
    end
    check(seen == 0, "R5 hold while line low", seen, 0);
    enable = 1'b0; stretch = 0;
    @(negedge clk); @(negedge clk);

    // R7 zero reload
    reloadVal = '0; enable = 1'b1;
    @(negedge clk);
    check(reloadInvalid == 1'b1, "R7 flag", int'(reloadInvalid), 1);
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      if (sclDriveLow) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R7 no drive", seen, 0);
    enable = 1'b0;
    @(negedge clk);
    check(reloadInvalid == 1'b0, "R7 flag clears", int'(reloadInvalid), 0);

    // R8 disable mid-low then restart
    reloadVal = 9'd10; enable = 1'b1;
    repeat (6) @(negedge clk);
    check(sclDriveLow == 1'b1, "R8 low before disable", int'(sclDriveLow), 1);
    enable = 1'b0;
    @(negedge clk);
    check(sclDriveLow == 1'b0, "R8 released", int'(sclDriveLow), 0);
    check(phaseTick == 1'b0, "R8 no tick", int'(phaseTick), 0);
    @(negedge clk);
    period(10, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule